// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block generates the digital reference level for a boost LED driver's feedback loop once the driver is enabled. It does not jump to the target level. Instead it climbs through the 5-bit level codes one step at a time, and every step lasts a fixed number of clock cycles. The climb covers 32 step periods when the target is full scale. A level-to-millivolt lookup, which is coarse at the top and fine at the bottom, turns the applied code into the reference value that an analog stage would follow.

A second timer starts at enable and keeps a flag high that asks the switch to use half of its normal current limit during early start-up. A command receiver can supply a new 5-bit target at any time while the block is enabled. If the target arrives during the climb, it becomes the new endpoint. If it arrives after the climb has finished, it is applied at once. When enable drops, the block shuts down. Shutdown clears all progress, and the next enable starts again from code zero.

Top module: `ssref_top`

## Requirements
- R1: While reset is held, and after it is released with enable low, the step index is 0, the reference is 0 mV, and ramp-done and half-limit are both low.
- R2: Half-limit goes high on the first clock edge that samples enable high. It then stays high for exactly HALF_CYCLES cycles and falls after that.
- R3: The step index is 0 after the first enabled edge. During the ramp it rises by exactly one every STEP_CYCLES cycles and never changes in any other way.
- R4: With the default target (code 31), ramp-done rises STEP_CYCLES×32 cycles after the first enabled edge. At that point the index is 31 and the reference is 200 mV. Ramp-done then stays high while enable is high.
- R5: The reference maps from the applied code as follows: code 0 gives 0 mV. Codes 1 to 12 give 5 mV plus 3 mV per code above 1. Codes 12 to 23 add 6 mV per code above 12 onto 38 mV. Codes 23 to 31 add 12 mV per code above 23 onto 104 mV.
- R6: A target strobed in during the ramp becomes the endpoint. Ramp-done rises at the end of the first step period in which the index is at or above that target. From then on, the output shows the target.
- R7: A target strobed in after ramp-done is shown on the index and the reference one clock later, without any ramp.
- R8: On a clock edge that samples enable low, the index, ramp-done and half-limit all clear on that same edge. The target returns to code 31, and a target strobe sent while enable is low has no effect.
- R9: Each new enable after shutdown restarts the ramp from code 0 and restarts the half-limit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable level; low means shutdown |
| lvlStrobe | input | 1 | One-cycle strobe that loads a new target level |
| lvlCode | input | 5 | Target level code loaded by lvlStrobe |
| stepIdx | output | 5 | Level code currently applied |
| refMv | output | 8 | Reference in millivolts for stepIdx |
| rampDone | output | 1 | High once the ramp has reached its endpoint |
| halfLimit | output | 1 | Request for half switch current limit |

## Verification
The bench builds the block with a step period of 4 cycles and a half-limit window of 50 cycles. With these values a full ramp takes 128 cycles, so every step edge and the ramp-done edge can be reached quickly. The half-limit window also ends partway through the ramp, which lets the bench check both of its edges against the step counter. The short ramp also leaves time to sweep all 32 codes through the millivolt table, to lower and raise the endpoint in the middle of the climb, and to shut down and restart within one short run.

// File: rtl/ssref_pkg.sv
`timescale 1ns/1ps
package ssref_pkg;
  localparam int LVL_W    = 5;
  localparam int MV_W     = 8;
  localparam int FULL_LVL = (1 << LVL_W) - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // shutdown: drop all progress
    logic advance;  // step period expired, move to next code
    logic finish;   // step period expired at endpoint
    logic load;     // take a new target
  } seqStrobe_t;

  // pseudo-logarithmic code to millivolt map
  function automatic logic [MV_W-1:0] lvlToMv(input logic [LVL_W-1:0] code);
    int c;
    int v;
    c = int'(code);
    if (c == 0)       v = 0;
    else if (c <= 12) v = 5 + 3 * (c - 1);
    else if (c <= 23) v = 38 + 6 * (c - 12);
    else              v = 104 + 12 * (c - 23);
    return MV_W'(v);
  endfunction
endpackage

// File: rtl/ssref_ctrl.sv
`timescale 1ns/1ps
module ssref_ctrl
  import ssref_pkg::*;
#(
  parameter int STEP_CYCLES = 27264,
  parameter int HALF_CYCLES = 640000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       lvlStrobe,
  input  logic       rampDone,
  input  logic       atEnd,
  output seqStrobe_t strobes,
  output logic       halfLimit
);
  localparam int STEP_W = $clog2(STEP_CYCLES + 1);
  localparam int HALF_W = $clog2(HALF_CYCLES + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [HALF_W-1:0] HALF_MAX  = HALF_W'(HALF_CYCLES);

  logic              runQ;
  logic [STEP_W-1:0] stepTimer;
  logic [HALF_W-1:0] halfTimer;
  logic              expire;

  assign expire = runQ && !rampDone && (stepTimer == STEP_LAST);

  always_comb begin
    strobes         = '0;
    strobes.clear   = !en;
    strobes.advance = en && expire && !atEnd;
    strobes.finish  = en && expire && atEnd;
    strobes.load    = en && lvlStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      stepTimer <= '0;
      halfTimer <= '0;
    end else if (!en) begin
      runQ      <= 1'b0;
      stepTimer <= '0;
      halfTimer <= '0;
    end else begin
      runQ <= 1'b1;
      if (runQ && !rampDone) begin
        if (expire) stepTimer <= '0;
        else        stepTimer <= stepTimer + STEP_W'(1);
      end
      if (runQ && (halfTimer != HALF_MAX))
        halfTimer <= halfTimer + HALF_W'(1);
    end
  end

  assign halfLimit = runQ && (halfTimer != HALF_MAX);
endmodule

// File: rtl/ssref_path.sv
`timescale 1ns/1ps
module ssref_path
  import ssref_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobes,
  input  logic [LVL_W-1:0] lvlCode,
  output logic             rampDone,
  output logic             atEnd,
  output logic [LVL_W-1:0] stepIdx,
  output logic [MV_W-1:0]  refMv
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FULL_LVL);

  logic [LVL_W-1:0] rampCnt;
  logic [LVL_W-1:0] tgtCode;
  logic             doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCnt <= '0;
      tgtCode <= FULL;
      doneQ   <= 1'b0;
    end else if (strobes.clear) begin
      rampCnt <= '0;
      tgtCode <= FULL;
      doneQ   <= 1'b0;
    end else begin
      if (strobes.load)    tgtCode <= lvlCode;
      if (strobes.advance) rampCnt <= rampCnt + LVL_W'(1);
      if (strobes.finish)  doneQ   <= 1'b1;
    end
  end

  assign atEnd    = (rampCnt >= tgtCode);
  assign rampDone = doneQ;
  assign stepIdx  = doneQ ? tgtCode : rampCnt;
  assign refMv    = lvlToMv(stepIdx);
endmodule

// File: rtl/ssref_top.sv
`timescale 1ns/1ps
module ssref_top
  import ssref_pkg::*;
#(
  parameter int STEP_CYCLES = 27264,
  parameter int HALF_CYCLES = 640000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       lvlStrobe,
  input  logic [4:0] lvlCode,
  output logic [4:0] stepIdx,
  output logic [7:0] refMv,
  output logic       rampDone,
  output logic       halfLimit
);
  seqStrobe_t strobes;
  logic       atEnd;
  logic       doneInt;

  ssref_ctrl #(
    .STEP_CYCLES(STEP_CYCLES),
    .HALF_CYCLES(HALF_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (en),
    .lvlStrobe(lvlStrobe),
    .rampDone (doneInt),
    .atEnd    (atEnd),
    .strobes  (strobes),
    .halfLimit(halfLimit)
  );

  ssref_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lvlCode (lvlCode),
    .rampDone(doneInt),
    .atEnd   (atEnd),
    .stepIdx (stepIdx),
    .refMv   (refMv)
  );

  assign rampDone = doneInt;
endmodule

// File: rtl/ssref_check.sv
`timescale 1ns/1ps
module ssref_check (
  input logic       clk,
  input logic       rstN,
  input logic       en,
  input logic [4:0] stepIdx,
  input logic [7:0] refMv,
  input logic       rampDone,
  input logic       halfLimit
);
  // R3: during the ramp the index holds or rises by one
  p_step_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    (en && !rampDone) |=> (rampDone || stepIdx == $past(stepIdx) ||
                           stepIdx == $past(stepIdx) + 5'd1));

  // R4: ramp-done is sticky while enabled
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && rampDone) |=> rampDone);

  // R8: shutdown clears on the same edge
  p_shutdown_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (stepIdx == 5'd0 && !rampDone && !halfLimit));

  // R2 and R9: half-limit starts together with a fresh ramp
  p_half_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfLimit) |-> (stepIdx == 5'd0 && !rampDone));

  // R5: code zero means zero millivolts
  p_zero_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == 5'd0) |-> (refMv == 8'd0));
endmodule

bind ssref_top ssref_check u_check (
  .clk      (clk),
  .rstN     (rstN),
  .en       (en),
  .stepIdx  (stepIdx),
  .refMv    (refMv),
  .rampDone (rampDone),
  .halfLimit(halfLimit)
);

// File: tb/ssref_top_test.sv
`timescale 1ns/1ps
module ssref_top_test;
  localparam int STEP = 4;
  localparam int HALF = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic       lvlStrobe = 1'b0;
  logic [4:0] lvlCode = 5'd0;
  logic [4:0] stepIdx;
  logic [7:0] refMv;
  logic       rampDone;
  logic       halfLimit;

  int errors = 0;
  int checks = 0;
  int t = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ssref_top #(.STEP_CYCLES(STEP), .HALF_CYCLES(HALF)) uut (
    .clk(clk), .rstN(rstN), .en(en), .lvlStrobe(lvlStrobe), .lvlCode(lvlCode),
    .stepIdx(stepIdx), .refMv(refMv), .rampDone(rampDone), .halfLimit(halfLimit)
  );

  function automatic int expMv(input int c);
    if (c == 0)      return 0;
    else if (c < 13) return 2 + 3 * c;
    else if (c < 24) return 6 * c - 34;
    else             return 12 * c - 172;
  endfunction

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0d)", req, what, act, exp, t);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic goTo(input int target);
    adv(target - t);
  endtask

  task automatic shutdown();
    @(negedge clk);
    en = 1'b0;
    lvlStrobe = 1'b0;
    adv(2);
  endtask

  task automatic enableNow();
    @(negedge clk);
    en = 1'b1;
    t = 0;
  endtask

  task automatic testReset();
    checkEq("R1", "idx in reset", int'(stepIdx), 0);
    checkEq("R1", "half in reset", int'(halfLimit), 0);
    @(negedge clk); rstN = 1'b1;
    adv(3);
    checkEq("R1", "idx idle", int'(stepIdx), 0);
    checkEq("R1", "mv idle", int'(refMv), 0);
    checkEq("R1", "done idle", int'(rampDone), 0);
    checkEq("R1", "half idle", int'(halfLimit), 0);
  endtask

  task automatic testFullRamp();
    enableNow();
    goTo(1);
    checkEq("R3", "idx first", int'(stepIdx), 0);
    checkEq("R2", "half first", int'(halfLimit), 1);
    goTo(STEP);
    checkEq("R3", "idx end step0", int'(stepIdx), 0);
    goTo(STEP + 1);
    checkEq("R3", "idx step1", int'(stepIdx), 1);
    goTo(HALF);
    checkEq("R2", "half last", int'(halfLimit), 1);
    checkEq("R3", "idx mid", int'(stepIdx), (HALF - 1) / STEP);
    goTo(HALF + 1);
    checkEq("R2", "half off", int'(halfLimit), 0);
    goTo(32 * STEP);
    checkEq("R4", "idx before done", int'(stepIdx), 31);
    checkEq("R4", "done early", int'(rampDone), 0);
    goTo(32 * STEP + 1);
    checkEq("R4", "done", int'(rampDone), 1);
    checkEq("R4", "mv full", int'(refMv), 200);
    goTo(32 * STEP + 20);
    checkEq("R4", "done held", int'(rampDone), 1);
    checkEq("R4", "idx held", int'(stepIdx), 31);
    shutdown();
  endtask

  task automatic testMidRaise();
    enableNow();
    goTo(2);
    lvlCode = 5'd5; lvlStrobe = 1'b1;
    goTo(3);
    lvlStrobe = 1'b0;
    goTo(6 * STEP);
    checkEq("R6", "idx at end", int'(stepIdx), 5);
    checkEq("R6", "not yet done", int'(rampDone), 0);
    goTo(6 * STEP + 1);
    checkEq("R6", "done at 5", int'(rampDone), 1);
    checkEq("R6", "idx stop", int'(stepIdx), 5);
    checkEq("R6", "mv 5", int'(refMv), 17);
    shutdown();
  endtask

  task automatic testMidLower();
    enableNow();
    goTo(10 * STEP + 2);
    checkEq("R3", "idx 10", int'(stepIdx), 10);
    lvlCode = 5'd3; lvlStrobe = 1'b1;
    adv(1);
    lvlStrobe = 1'b0;
    goTo(11 * STEP);
    checkEq("R6", "idx held 10", int'(stepIdx), 10);
    checkEq("R6", "done early", int'(rampDone), 0);
    goTo(11 * STEP + 1);
    checkEq("R6", "done lowered", int'(rampDone), 1);
    checkEq("R6", "idx lowered", int'(stepIdx), 3);
    checkEq("R6", "mv lowered", int'(refMv), 11);
    shutdown();
  endtask

  task automatic testAfterDone();
    enableNow();
    goTo(32 * STEP + 1);
    checkEq("R4", "done", int'(rampDone), 1);
    lvlCode = 5'd12; lvlStrobe = 1'b1;
    adv(1);
    lvlStrobe = 1'b0;
    checkEq("R7", "idx 12", int'(stepIdx), 12);
    checkEq("R7", "mv 12", int'(refMv), 38);
    for (int c = 0; c < 32; c++) begin
      lvlCode = 5'(c); lvlStrobe = 1'b1;
      adv(1);
      lvlStrobe = 1'b0;
      checkEq("R5", "idx sweep", int'(stepIdx), c);
      checkEq("R5", "mv sweep", int'(refMv), expMv(c));
    end
    shutdown();
  endtask

  task automatic testShutdown();
    enableNow();
    goTo(20);
    en = 1'b0;
    adv(1);
    checkEq("R8", "idx cleared", int'(stepIdx), 0);
    checkEq("R8", "done cleared", int'(rampDone), 0);
    checkEq("R8", "half cleared", int'(halfLimit), 0);
    checkEq("R8", "mv cleared", int'(refMv), 0);
    lvlCode = 5'd4; lvlStrobe = 1'b1;
    adv(1);
    lvlStrobe = 1'b0;
    checkEq("R8", "strobe ignored idx", int'(stepIdx), 0);
    enableNow();
    goTo(1);
    checkEq("R9", "restart idx", int'(stepIdx), 0);
    checkEq("R9", "restart half", int'(halfLimit), 1);
    goTo(5 * STEP + 1);
    checkEq("R9", "idx past 4", int'(stepIdx), 5);
    goTo(32 * STEP + 1);
    checkEq("R8", "target back to 31", int'(stepIdx), 31);
    checkEq("R9", "done again", int'(rampDone), 1);
    shutdown();
  endtask

  initial begin
    testReset();
    testFullRamp();
    testMidRaise();
    testMidLower();
    testAfterDone();
    testShutdown();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule